// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block keeps a table of programmable address windows that steer processor accesses to on-chip devices. Each window has an enable, a 4-bit device target, an 8-bit attribute, a 36-bit base and a size that is a multiple of 64 KiB. The lower-numbered windows also carry a remap base, so an access can land at a different device address.

Software programs the table through a simple 32-bit register port. The write takes effect on the clock edge. The read is combinational. A purely combinational lookup port takes a 36-bit physical address. It returns whether a window matched, the index of that window, its target and attribute, and the translated address.

Neither port has a handshake. The register port accepts one write per cycle with no back-pressure. The lookup answer is valid in the same cycle as its address. The window count, the number of windows that can be remapped, and one of three register offset layouts are chosen by parameters.

Top module: `addr_window_map`

## Requirements
- R1: After reset every window is disabled, every register offset reads zero and every lookup misses.
- R2: The control register holds enable in bit 0, target in bits 7:4, attribute in bits 15:8 and size-minus-one in 64 KiB units in bits 31:16; bits 3:1 read back as zero.
- R3: The base register holds address bits 31:16 in its bits 31:16 and address bits 35:32 in its bits 3:0; all other bits read back as zero.
- R4: An enabled window matches an address a when base <= a < base + (size field + 1) * 65536; a disabled window never matches.
- R5: When several windows match, the lowest index is reported.
- R6: For a window whose index is below NUM_REMAP, the translated address is the remap base plus (a - base). The remap base is {high[3:0], low[31:16], 16 zero bits}. Remap-low keeps only bits 31:16 and remap-high keeps only bits 3:0.
- R7: Windows at or above NUM_REMAP have no remap registers, and their remap offsets are unmapped. Their translated address equals the input address.
- R8: With LAYOUT=1 (split), windows 0-7 sit at 16*i with control at +0, base at +4, remap-low at +8 and remap-high at +0xC. Windows 8 and up sit at 0x90 + 8*(i-8) with control at +0 and base at +4. Offsets 0x80-0x8F are a hole. LAYOUT=0 puts every window at 16*i. LAYOUT=2 puts windows 8 and up at 0x900 + 16*(i-8).
- R9: Unmapped or misaligned offsets, including the hole, read zero, and writes to them change no register.
- R10: Writing a control register with bit 0 clear also clears that window's base and remap registers.
- R11: On a miss, hit, index, target and attribute are zero and the translated address equals the input address.
- R12: A register write is visible on the lookup port from the cycle after the write edge, and without writes the lookup result for a held address does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | OFS_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| lk_addr | input | 36 | Address to decode |
| lk_hit | output | 1 | A window matched |
| lk_target | output | 4 | Target of the matching window |
| lk_attr | output | 8 | Attribute of the matching window |
| lk_win | output | IDX_W | Index of the matching window |
| lk_xaddr | output | 36 | Translated address |

## Verification
The assertions check four things on every cycle: the miss outputs stay clean, the reported index stays in range, non-remappable windows pass the address through, and the hole reads zero. They also check that after reset the lookup result holds steady when no write occurs. Priority between overlapping windows, the remap arithmetic, the clearing done by a disabling write, and the exact offset map can only be shown by the bench scenarios. These scenarios sweep every register offset against a computed model and probe the lookup port on a coarse grid and at every window edge.

// File: rtl/awm_pkg.sv
package awm_pkg;
  localparam int LAYOUT_FLAT  = 0;
  localparam int LAYOUT_SPLIT = 1;
  localparam int LAYOUT_FAR   = 2;
  localparam int PA_W         = 36;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_BASE = 2'd1,
    SEL_RLO  = 2'd2,
    SEL_RHI  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic        en;
    logic [3:0]  tgt;
    logic [7:0]  attr;
    logic [15:0] sz;       // size/64KiB - 1
    logic [3:0]  base_hi;  // address 35:32
    logic [15:0] base_lo;  // address 31:16
    logic [3:0]  rmp_hi;
    logic [15:0] rmp_lo;
  } win_t;
endpackage

// File: rtl/awm_ofs_decode.sv
module awm_ofs_decode
  import awm_pkg::*;
#(
  parameter int NUM_WIN   = 20,
  parameter int NUM_REMAP = 8,
  parameter int LAYOUT    = LAYOUT_SPLIT,
  parameter int OFS_W     = 12,
  parameter int IDX_W     = 5
) (
  input  logic [OFS_W-1:0] ofs,
  output logic             hit,
  output logic [IDX_W-1:0] idx,
  output reg_sel_e         sel
);
  localparam int HI_BYTES = (NUM_WIN > 8) ? (NUM_WIN - 8) * 8 : 0;

  logic       raw_hit;
  int         raw_w;
  logic [1:0] raw_r;
  int         o;

  assign o = int'(ofs);

  generate
    if (LAYOUT == LAYOUT_SPLIT) begin : g_split
      always_comb begin
        raw_hit = 1'b0;
        raw_w   = 0;
        raw_r   = 2'd0;
        if (o < 'h80) begin
          raw_w   = o >> 4;
          raw_r   = ofs[3:2];
          raw_hit = raw_w < NUM_WIN;
        end else if (o >= 'h90 && o < 'h90 + HI_BYTES) begin
          raw_w   = 8 + ((o - 'h90) >> 3);
          raw_r   = {1'b0, ofs[2]};
          raw_hit = 1'b1;
        end
      end
    end else if (LAYOUT == LAYOUT_FAR) begin : g_far
      always_comb begin
        raw_hit = 1'b0;
        raw_w   = 0;
        raw_r   = ofs[3:2];
        if (o < 'h80) begin
          raw_w   = o >> 4;
          raw_hit = raw_w < NUM_WIN;
        end else if (o >= 'h900) begin
          raw_w   = 8 + ((o - 'h900) >> 4);
          raw_hit = raw_w < NUM_WIN;
        end
      end
    end else begin : g_flat
      always_comb begin
        raw_w   = o >> 4;
        raw_r   = ofs[3:2];
        raw_hit = raw_w < NUM_WIN;
      end
    end
  endgenerate

  always_comb begin
    hit = raw_hit && (ofs[1:0] == 2'b00) && !(raw_r[1] && raw_w >= NUM_REMAP);
    idx = hit ? IDX_W'(raw_w) : '0;
    sel = reg_sel_e'(raw_r);
  end
endmodule

// File: rtl/awm_win_regs.sv
module awm_win_regs
  import awm_pkg::*;
#(
  parameter int NUM_WIN = 20,
  parameter int IDX_W   = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic                     dec_hit,
  input  logic [IDX_W-1:0]         dec_idx,
  input  reg_sel_e                 dec_sel,
  input  logic [31:0]              wdata,
  output logic [31:0]              rdata,
  output win_t [NUM_WIN-1:0]       wins
);
  win_t cur;
  logic unused_wbits;

  assign unused_wbits = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wins <= '0;
    end else if (we && dec_hit) begin
      unique case (dec_sel)
        SEL_CTRL: begin
          wins[dec_idx].en   <= wdata[0];
          wins[dec_idx].tgt  <= wdata[7:4];
          wins[dec_idx].attr <= wdata[15:8];
          wins[dec_idx].sz   <= wdata[31:16];
          if (!wdata[0]) begin
            wins[dec_idx].base_hi <= '0;
            wins[dec_idx].base_lo <= '0;
            wins[dec_idx].rmp_hi  <= '0;
            wins[dec_idx].rmp_lo  <= '0;
          end
        end
        SEL_BASE: begin
          wins[dec_idx].base_lo <= wdata[31:16];
          wins[dec_idx].base_hi <= wdata[3:0];
        end
        SEL_RLO: wins[dec_idx].rmp_lo <= wdata[31:16];
        SEL_RHI: wins[dec_idx].rmp_hi <= wdata[3:0];
      endcase
    end
  end

  always_comb begin
    cur   = wins[dec_idx];
    rdata = '0;
    if (dec_hit) begin
      unique case (dec_sel)
        SEL_CTRL: rdata = {cur.sz, cur.attr, cur.tgt, 3'b000, cur.en};
        SEL_BASE: rdata = {cur.base_lo, 12'h000, cur.base_hi};
        SEL_RLO:  rdata = {cur.rmp_lo, 16'h0000};
        SEL_RHI:  rdata = {28'h0, cur.rmp_hi};
      endcase
    end
  end
endmodule

// File: rtl/awm_match.sv
module awm_match
  import awm_pkg::*;
#(
  parameter int NUM_WIN   = 20,
  parameter int NUM_REMAP = 8,
  parameter int IDX_W     = 5
) (
  input  win_t [NUM_WIN-1:0] wins,
  input  logic [PA_W-1:0]    addr,
  output logic               hit,
  output logic [IDX_W-1:0]   win,
  output logic [3:0]         tgt,
  output logic [7:0]         attr,
  output logic [PA_W-1:0]    xaddr
);
  logic [NUM_WIN-1:0]           m;
  logic [NUM_WIN-1:0][PA_W-1:0] xa;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    logic [PA_W-1:0] wb;
    logic [PA_W:0]   we_end;
    assign wb     = {wins[i].base_hi, wins[i].base_lo, 16'h0000};
    assign we_end = {1'b0, wb} + ((PA_W+1)'({wins[i].sz, 16'hFFFF}) + 1'b1);
    assign m[i]   = wins[i].en && (addr >= wb) && ({1'b0, addr} < we_end);
    if (i < NUM_REMAP) begin : g_rmp
      assign xa[i] = {wins[i].rmp_hi, wins[i].rmp_lo, 16'h0000} + (addr - wb);
    end else begin : g_pass
      assign xa[i] = addr;
    end
  end

  always_comb begin
    hit   = 1'b0;
    win   = '0;
    tgt   = '0;
    attr  = '0;
    xaddr = addr;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (m[i]) begin
        hit   = 1'b1;
        win   = IDX_W'(i);
        tgt   = wins[i].tgt;
        attr  = wins[i].attr;
        xaddr = xa[i];
      end
    end
  end
endmodule

// File: rtl/addr_window_map.sv
module addr_window_map
  import awm_pkg::*;
#(
  parameter int NUM_WIN   = 20,
  parameter int NUM_REMAP = 8,
  parameter int LAYOUT    = LAYOUT_SPLIT,
  parameter int OFS_W     = 12,
  parameter int IDX_W     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [OFS_W-1:0] reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [35:0]      lk_addr,
  output logic             lk_hit,
  output logic [3:0]       lk_target,
  output logic [7:0]       lk_attr,
  output logic [IDX_W-1:0] lk_win,
  output logic [35:0]      lk_xaddr
);
  logic               dec_hit;
  logic [IDX_W-1:0]   dec_idx;
  reg_sel_e           dec_sel;
  win_t [NUM_WIN-1:0] wins;

  awm_ofs_decode #(
    .NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .LAYOUT(LAYOUT),
    .OFS_W(OFS_W), .IDX_W(IDX_W)
  ) u_dec (
    .ofs(reg_addr), .hit(dec_hit), .idx(dec_idx), .sel(dec_sel)
  );

  awm_win_regs #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we),
    .dec_hit(dec_hit), .dec_idx(dec_idx), .dec_sel(dec_sel),
    .wdata(reg_wdata), .rdata(reg_rdata), .wins(wins)
  );

  awm_match #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .IDX_W(IDX_W)) u_match (
    .wins(wins), .addr(lk_addr), .hit(lk_hit), .win(lk_win),
    .tgt(lk_target), .attr(lk_attr), .xaddr(lk_xaddr)
  );
endmodule

// File: rtl/awm_checker.sv
module awm_checker #(
  parameter int NUM_WIN   = 20,
  parameter int NUM_REMAP = 8,
  parameter int LAYOUT    = 1,
  parameter int OFS_W     = 12,
  parameter int IDX_W     = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [OFS_W-1:0] reg_addr,
  input logic [31:0]      reg_rdata,
  input logic [35:0]      lk_addr,
  input logic             lk_hit,
  input logic [3:0]       lk_target,
  input logic [7:0]       lk_attr,
  input logic [IDX_W-1:0] lk_win,
  input logic [35:0]      lk_xaddr
);
  AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_target == 4'h0 && lk_attr == 8'h00 && lk_win == '0 && lk_xaddr == lk_addr)); // R11

  AST_WIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (int'(lk_win) < NUM_WIN)); // R5

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && int'(lk_win) >= NUM_REMAP) |-> (lk_xaddr == lk_addr)); // R7

  AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (LAYOUT == 1 && reg_addr >= OFS_W'(128) && reg_addr < OFS_W'(144)) |-> (reg_rdata == 32'h0)); // R9

  AST_RESET_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!lk_hit && reg_rdata == 32'h0)); // R1

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(reg_we) && $stable(lk_addr)) |-> ($stable(lk_hit) && $stable(lk_win) && $stable(lk_xaddr))); // R12
endmodule

bind addr_window_map awm_checker #(
  .NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .LAYOUT(LAYOUT),
  .OFS_W(OFS_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .lk_addr(lk_addr), .lk_hit(lk_hit),
  .lk_target(lk_target), .lk_attr(lk_attr), .lk_win(lk_win),
  .lk_xaddr(lk_xaddr)
);

// File: tb/addr_window_map_test.sv
module addr_window_map_test;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 10;
  localparam int NR = 4;
  localparam int OW = 12;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [OW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [35:0]   lk_addr = '0;
  logic          lk_hit;
  logic [3:0]    lk_target;
  logic [7:0]    lk_attr;
  logic [IW-1:0] lk_win;
  logic [35:0]   lk_xaddr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1234_5678;

  logic [31:0] m_ctrl [NW];
  logic [31:0] m_base [NW];
  logic [31:0] m_rlo  [NW];
  logic [31:0] m_rhi  [NW];

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_window_map #(.NUM_WIN(NW), .NUM_REMAP(NR), .LAYOUT(1), .OFS_W(OW), .IDX_W(IW)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_target(lk_target), .lk_attr(lk_attr),
    .lk_win(lk_win), .lk_xaddr(lk_xaddr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit m_dec(input int o, output int w, output int r);
    w = 0; r = 0;
    if (o % 4 != 0) return 0;
    if (o < 'h80) begin
      w = o / 16; r = (o / 4) % 4;
      return !(r >= 2 && w >= NR) && w < NW;
    end
    if (o >= 'h90 && o < 'h90 + (NW - 8) * 8) begin
      w = 8 + (o - 'h90) / 8; r = (o / 4) % 2;
      return 1;
    end
    return 0;
  endfunction

  function automatic int ctrl_ofs(input int w);
    return (w < 8) ? w * 16 : 'h90 + (w - 8) * 8;
  endfunction

  task automatic m_write(input int o, input logic [31:0] d);
    int w, r;
    if (m_dec(o, w, r)) begin
      case (r)
        0: begin
          m_ctrl[w] = d & 32'hFFFF_FFF1;
          if (!d[0]) begin m_base[w] = 0; m_rlo[w] = 0; m_rhi[w] = 0; end
        end
        1: m_base[w] = d & 32'hFFFF_000F;
        2: m_rlo[w]  = d & 32'hFFFF_0000;
        default: m_rhi[w] = d & 32'h0000_000F;
      endcase
    end
  endtask

  function automatic logic [31:0] m_read(input int o);
    int w, r;
    if (!m_dec(o, w, r)) return 32'h0;
    case (r)
      0: return m_ctrl[w];
      1: return m_base[w];
      2: return m_rlo[w];
      default: return m_rhi[w];
    endcase
  endfunction

  function automatic logic [52:0] m_look(input logic [35:0] a);
    logic [35:0] b;
    logic [36:0] sz;
    for (int i = 0; i < NW; i++) begin
      if (m_ctrl[i][0]) begin
        b  = {m_base[i][3:0], m_base[i][31:16], 16'h0};
        sz = (37'(m_ctrl[i][31:16]) + 37'd1) << 16;
        if (a >= b && 37'(a) < 37'(b) + sz)
          return {1'b1, 4'(i), m_ctrl[i][7:4], m_ctrl[i][15:8],
                  (i < NR) ? ({m_rhi[i][3:0], m_rlo[i][31:16], 16'h0} + (a - b)) : a};
      end
    end
    return {1'b0, 4'h0, 4'h0, 8'h00, a};
  endfunction

  task automatic wr(input int o, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = OW'(o); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    m_write(o, d);
  endtask

  task automatic rd_chk(input int o, input string req);
    reg_addr = OW'(o);
    #1;
    chk(req, 64'(reg_rdata), 64'(m_read(o)));
  endtask

  task automatic lk_chk(input logic [35:0] a, input string req);
    lk_addr = a;
    #1;
    chk(req, 64'({lk_hit, lk_win, lk_target, lk_attr, lk_xaddr}), 64'(m_look(a)));
  endtask

  task automatic sweep_regs(input string req);
    for (int o = 0; o < 'h1000; o += 4) rd_chk(o, req);
    rd_chk('h02, req);
    rd_chk('h91, req);
  endtask

  task automatic edges(input string req);
    logic [35:0] b;
    logic [36:0] e;
    for (int i = 0; i < NW; i++) begin
      if (m_ctrl[i][0]) begin
        b = {m_base[i][3:0], m_base[i][31:16], 16'h0};
        e = 37'(b) + ((37'(m_ctrl[i][31:16]) + 37'd1) << 16);
        lk_chk(b - 36'd1, req);
        lk_chk(b, req);
        lk_chk(36'(e - 37'd1), req);
        lk_chk(36'(e), req);
      end
    end
  endtask

  initial begin
    for (int i = 0; i < NW; i++) begin
      m_ctrl[i] = 0; m_base[i] = 0; m_rlo[i] = 0; m_rhi[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: everything cleared
    sweep_regs("R1 reset readback");
    for (int k = 0; k < 64; k++) lk_chk(36'(k) << 30, "R1 reset lookup miss");

    // R2 R3 R6 R8 R9: pseudo-random fill of every offset incl. hole and beyond
    for (int o = 0; o < 'h100; o += 4) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      wr(o, seed);
    end
    sweep_regs("R8 R9 offset map after fill");
    for (int k = 0; k < 4096; k++) lk_chk(36'(k) << 24, "R4 grid lookup");
    edges("R4 R5 window edges");

    // clear every window: R10
    for (int w = 0; w < NW; w++) wr(ctrl_ofs(w), 32'h0);
    sweep_regs("R10 cleared table");

    // directed scenario
    wr('h00, 32'h000F_5A3F);
    rd_chk('h00, "R2 ctrl bits 3:1 read zero");
    chk("R2 ctrl readback", 64'(reg_rdata), 64'h000F_5A31);
    wr('h04, 32'hFFFF_FFFF);
    rd_chk('h04, "R3 base mask");
    chk("R3 base readback", 64'(reg_rdata), 64'hFFFF_000F);
    wr('h04, 32'h2000_0001);
    wr('h08, 32'h0030_1234);
    rd_chk('h08, "R6 remap low mask");
    wr('h0C, 32'hFFFF_FFF0);
    rd_chk('h0C, "R6 remap high mask");
    wr('h20, 32'h00FF_1171);
    wr('h24, 32'h2000_0001);
    lk_addr = 36'h1_2000_1234; #1;
    chk("R5 lowest index wins", 64'({lk_hit, lk_win}), 64'({1'b1, 4'd0}));
    chk("R6 translated", 64'(lk_xaddr), 64'h0_0030_1234);
    chk("R2 target/attr", 64'({lk_target, lk_attr}), 64'({4'h3, 8'h5A}));
    lk_addr = 36'h1_2010_0000; #1;
    chk("R4 past end of win0", 64'({lk_hit, lk_win, lk_xaddr}), 64'({1'b1, 4'd2, 36'h0_0010_0000}));
    wr('h94, 32'h4000_0000);
    wr('h90, 32'h0000_01E1);
    lk_addr = 36'h0_4000_FFFF; #1;
    chk("R12 write visible next cycle / R7 pass-through",
        64'({lk_hit, lk_win, lk_target, lk_xaddr}), 64'({1'b1, 4'd8, 4'hE, 36'h0_4000_FFFF}));
    lk_addr = 36'h0_4001_0000; #1;
    chk("R11 miss outputs", 64'({lk_hit, lk_win, lk_target, lk_attr, lk_xaddr}),
        64'({1'b0, 4'd0, 4'h0, 8'h00, 36'h0_4001_0000}));
    wr('h58, 32'hFFFF_0000);
    rd_chk('h58, "R7 missing remap reg");
    chk("R7 missing remap reads zero", 64'(reg_rdata), 64'h0);
    wr('h84, 32'hFFFF_FFFF);
    wr('hA0, 32'hFFFF_FFFF);
    sweep_regs("R9 ignored writes");
    edges("R4 R6 directed edges");
    wr('h00, 32'h0000_0000);
    rd_chk('h04, "R10 base cleared");
    rd_chk('h08, "R10 remap cleared");
    chk("R10 base zero", 64'({m_base[0], m_rlo[0]}), 64'h0);
    lk_addr = 36'h1_2000_1234; #1;
    chk("R10 disabled window no longer matches", 64'({lk_hit, lk_win}), 64'({1'b1, 4'd2}));
    edges("R4 after disable");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule